// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a segmented logical address into a 24-bit physical address. A request carries a 16-bit segment selector, a 16-bit offset, an access kind (read, write or execute) and the privilege ring of the requesting code. The selector names one descriptor. The descriptor can come from a shared table that all tasks use or from a table that belongs to the running task. The descriptor gives the segment's physical base, its bound, its permission flags and the least-privileged ring that may use it.

Both tables sit in one small descriptor store inside the block. Two pointer registers mark where each table starts in that store and how many entries it holds. Ring-0 configuration writes fill the store and set the pointers. A context switch is done by rewriting the per-task pointer alone, and the shared pointer stays as it is. Each lookup takes two cycles, one to read the descriptor and one to check it and add the base. The block then holds a result with a fault code on a valid/ready output until that result is taken.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. Every descriptor is all zeros (base 0, bound 0, no permission flags, minimum ring 0). Both table pointers have start slot 0 and limit 0.
- R2: The selector is decoded as follows. Bits [15:3] are the table index. Bit 2 picks the table: 0 for the shared (global) table, 1 for the per-task (local) table. Bits [1:0] are the requested ring.
- R3: The descriptor slot is (table start + index) mod 32. An index larger than the chosen table's limit gives fault code 1 (limit).
- R4: Ring 0 is the most privileged. If the larger of the request ring and the selector's requested ring is numerically above the descriptor's minimum ring, the result is fault code 2 (privilege).
- R5: Access kind 0 (read) needs flag bit 0, kind 1 (write) needs flag bit 1 and kind 2 (execute) needs flag bit 2. A missing flag, or access kind 3, gives fault code 3 (permission).
- R6: An offset numerically above the descriptor bound gives fault code 4 (bound). An offset equal to the bound is allowed.
- R7: With no fault, rsp_fault is 0 and rsp_addr is (base + offset) mod 2^24. When any fault is reported, rsp_addr is 0.
- R8: When several checks fail, the one reported follows this order: limit, then privilege, then permission, then bound.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both 1. rsp_valid goes high after the second edge that follows the acceptance. req_ready stays low from the acceptance until the response is taken.
- R10: While rsp_valid is 1 and rsp_ready is 0, the response holds and does not change. It is taken on an edge where both are 1, and req_ready returns after that edge.
- R11: cfg_op selects the configuration action: 1 writes the descriptor at cfg_slot, 2 sets the global pointer and 3 sets the local pointer (start = cfg_slot, limit = cfg_limit). A configuration write is ignored when cfg_cpl is not 0. A lookup accepted on the same edge as a write sees the state from before that write.
- R12: After the local pointer is rewritten, selectors for the local table resolve through the new start and limit. Selectors for the global table resolve as they did before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_op | input | 2 | Configuration action: 0 none, 1 descriptor, 2 global pointer, 3 local pointer |
| cfg_cpl | input | 2 | Ring of the code issuing the configuration write |
| cfg_slot | input | 5 | Descriptor slot, or table start slot for pointer writes |
| cfg_base | input | 24 | Descriptor physical base |
| cfg_bound | input | 16 | Descriptor bound (largest legal offset) |
| cfg_perm | input | 3 | Descriptor flags: bit 0 read, bit 1 write, bit 2 execute |
| cfg_dpl | input | 2 | Descriptor least-privileged ring allowed |
| cfg_limit | input | 13 | Largest legal index for pointer writes |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_sel | input | 16 | Segment selector |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_cpl | input | 2 | Ring of the requesting code |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 24 | Physical address, 0 on fault |
| rsp_fault | output | 3 | 0 none, 1 limit, 2 privilege, 3 permission, 4 bound |

## Verification
The directed part places offsets just below, at and just above a bound. It walks each access kind against each flag, so a wrong flag bit stands out from a wrong comparison. Request rings and selector rings are varied separately to show that the larger of the two is what gets checked. Some requests fail two or three checks at once, which pins down the reporting order. Pointer rewrites show that global and local selectors are resolved through different pointers. A configuration write from a nonzero ring, and a write landing on the same edge as an accept, show whether the store is gated and whether it is read before the write. A long random phase then mixes lookups, configuration writes at random rings and random output stalls, and compares every cycle against a behavioural model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int PA_W   = 24;
  localparam int OFF_W  = 16;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = SEL_W - 3;
  localparam int PERM_W = 3;
  localparam int RING_W = 2;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LIMIT = 3'd1,
    FLT_PRIV  = 3'd2,
    FLT_PERM  = 3'd3,
    FLT_BOUND = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    CFG_NOP  = 2'd0,
    CFG_DESC = 2'd1,
    CFG_GPTR = 2'd2,
    CFG_LPTR = 2'd3
  } cfg_e;

  typedef struct packed {
    logic [PA_W-1:0]   base;
    logic [OFF_W-1:0]  bound;
    logic [PERM_W-1:0] perm;
    logic [RING_W-1:0] dpl;
  } desc_t;

  // larger ring number = less privileged
  function automatic logic [RING_W-1:0] f_eff_ring(input logic [RING_W-1:0] a,
                                                   input logic [RING_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic f_ring_ok(input logic [RING_W-1:0] cpl,
                                     input logic [RING_W-1:0] rpl,
                                     input logic [RING_W-1:0] dpl);
    return f_eff_ring(cpl, rpl) <= dpl;
  endfunction

  function automatic logic f_perm_ok(input logic [PERM_W-1:0] perm,
                                     input logic [1:0] acc);
    logic ok;
    case (acc)
      2'd0:    ok = perm[0];
      2'd1:    ok = perm[1];
      2'd2:    ok = perm[2];
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [PA_W-1:0] f_phys(input logic [PA_W-1:0] base,
                                             input logic [OFF_W-1:0] off);
    return base + PA_W'(off);
  endfunction

  function automatic fault_e f_judge(input logic over_limit,
                                     input desc_t d,
                                     input logic [RING_W-1:0] cpl,
                                     input logic [RING_W-1:0] rpl,
                                     input logic [1:0] acc,
                                     input logic [OFF_W-1:0] off);
    fault_e f;
    if (over_limit)                  f = FLT_LIMIT;
    else if (!f_ring_ok(cpl, rpl, d.dpl)) f = FLT_PRIV;
    else if (!f_perm_ok(d.perm, acc)) f = FLT_PERM;
    else if (off > d.bound)          f = FLT_BOUND;
    else                             f = FLT_NONE;
    return f;
  endfunction

endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store
  import seg_xlate_pkg::*;
#(
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  desc_t             wr_desc,
  input  logic              rd_en,
  input  logic [SLOT_W-1:0] rd_slot,
  output desc_t             rd_desc
);

  desc_t slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (wr_en && (wr_slot == SLOT_W'(s)))
        slot_q[s] <= wr_desc;
    end
  end

  // registered read: returns the contents before a same-edge write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_desc <= '0;
    else if (rd_en)
      rd_desc <= slot_q[rd_slot];
  end

endmodule

// File: rtl/seg_table_ptrs.sv
module seg_table_ptrs
  import seg_xlate_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int LIM_W  = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gptr_we,
  input  logic              lptr_we,
  input  logic [SLOT_W-1:0] wr_start,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              sel_local,
  input  logic [LIM_W-1:0]  sel_index,
  output logic [SLOT_W-1:0] slot,
  output logic              over_limit
);

  localparam int NTBL = 2;

  logic [SLOT_W-1:0] start_q [NTBL];
  logic [LIM_W-1:0]  limit_q [NTBL];

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    logic we;
    assign we = (t == 0) ? gptr_we : lptr_we;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[t] <= '0;
        limit_q[t] <= '0;
      end else if (we) begin
        start_q[t] <= wr_start;
        limit_q[t] <= wr_limit;
      end
    end
  end

  logic [SLOT_W-1:0] act_start;
  logic [LIM_W-1:0]  act_limit;

  always_comb begin
    act_start  = start_q[sel_local];
    act_limit  = limit_q[sel_local];
    slot       = act_start + sel_index[SLOT_W-1:0];
    over_limit = sel_index > act_limit;
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  desc_t             desc,
  input  logic              over_limit,
  input  logic [RING_W-1:0] cpl,
  input  logic [RING_W-1:0] rpl,
  input  logic [1:0]        acc,
  input  logic [OFF_W-1:0]  off,
  output fault_e            fault,
  output logic [PA_W-1:0]   addr
);

  always_comb begin
    fault = f_judge(over_limit, desc, cpl, rpl, acc, off);
    addr  = (fault == FLT_NONE) ? f_phys(desc.base, off) : '0;
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_op,
  input  logic [1:0]        cfg_cpl,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [23:0]       cfg_base,
  input  logic [15:0]       cfg_bound,
  input  logic [2:0]        cfg_perm,
  input  logic [1:0]        cfg_dpl,
  input  logic [12:0]       cfg_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_sel,
  input  logic [15:0]       req_off,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_cpl,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [23:0]       rsp_addr,
  output logic [2:0]        rsp_fault
);

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_RESP} state_e;

  state_e state_q;

  // named internal events
  logic accept, deliver, cfg_priv, desc_we, gptr_we, lptr_we;

  assign cfg_priv = (cfg_cpl == '0);
  assign desc_we  = cfg_priv && (cfg_e'(cfg_op) == CFG_DESC);
  assign gptr_we  = cfg_priv && (cfg_e'(cfg_op) == CFG_GPTR);
  assign lptr_we  = cfg_priv && (cfg_e'(cfg_op) == CFG_LPTR);

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign accept    = req_valid && req_ready;
  assign deliver   = rsp_valid && rsp_ready;

  // selector fields
  logic [IDX_W-1:0]  sel_index;
  logic              sel_local;
  logic [RING_W-1:0] sel_rpl;

  assign sel_index = req_sel[SEL_W-1:3];
  assign sel_local = req_sel[2];
  assign sel_rpl   = req_sel[1:0];

  desc_t wr_desc;
  assign wr_desc = '{base: cfg_base, bound: cfg_bound, perm: cfg_perm, dpl: cfg_dpl};

  logic [SLOT_W-1:0] rd_slot;
  logic              over_limit;
  desc_t             fetched;

  seg_table_ptrs #(.SLOT_W(SLOT_W), .LIM_W(IDX_W)) ptrs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gptr_we    (gptr_we),
    .lptr_we    (lptr_we),
    .wr_start   (cfg_slot),
    .wr_limit   (cfg_limit),
    .sel_local  (sel_local),
    .sel_index  (sel_index),
    .slot       (rd_slot),
    .over_limit (over_limit)
  );

  seg_desc_store #(.SLOTS(SLOTS)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (desc_we),
    .wr_slot (cfg_slot),
    .wr_desc (wr_desc),
    .rd_en   (accept),
    .rd_slot (rd_slot),
    .rd_desc (fetched)
  );

  // request fields captured at acceptance
  logic              over_q;
  logic [RING_W-1:0] cpl_q, rpl_q;
  logic [1:0]        acc_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q <= 1'b0;
      cpl_q  <= '0;
      rpl_q  <= '0;
      acc_q  <= '0;
      off_q  <= '0;
    end else if (accept) begin
      over_q <= over_limit;
      cpl_q  <= req_cpl;
      rpl_q  <= sel_rpl;
      acc_q  <= req_acc;
      off_q  <= req_off;
    end
  end

  fault_e          chk_fault;
  logic [PA_W-1:0] chk_addr;

  seg_check check_i (
    .desc       (fetched),
    .over_limit (over_q),
    .cpl        (cpl_q),
    .rpl        (rpl_q),
    .acc        (acc_q),
    .off        (off_q),
    .fault      (chk_fault),
    .addr       (chk_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_addr  <= '0;
      rsp_fault <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_CHECK;
        ST_CHECK: begin
          state_q   <= ST_RESP;
          rsp_addr  <= chk_addr;
          rsp_fault <= chk_fault;
        end
        ST_RESP:  if (deliver) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [23:0] rsp_addr,
  input logic [2:0]  rsp_fault,
  input logic [1:0]  cfg_cpl,
  input logic        accept,
  input logic        desc_we,
  input logic        gptr_we,
  input logic        lptr_we
);

  // R9
  acc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rsp_valid);

  // R9
  acc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 rsp_valid);

  // R9
  one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

  // R10
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

  // R7
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_addr == 24'd0));

  // R3
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));

  // R11
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we || gptr_we || lptr_we) |-> (cfg_cpl == 2'd0));

  // R11
  cfg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_we, gptr_we, lptr_we}));

endmodule

bind seg_xlate_unit seg_xlate_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault),
  .cfg_cpl   (cfg_cpl),
  .accept    (accept),
  .desc_we   (desc_we),
  .gptr_we   (gptr_we),
  .lptr_we   (lptr_we)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_op = 2'd0;
  logic [1:0]  cfg_cpl = 2'd0;
  logic [4:0]  cfg_slot = 5'd0;
  logic [23:0] cfg_base = 24'd0;
  logic [15:0] cfg_bound = 16'd0;
  logic [2:0]  cfg_perm = 3'd0;
  logic [1:0]  cfg_dpl = 2'd0;
  logic [12:0] cfg_limit = 13'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = 16'd0;
  logic [15:0] req_off = 16'd0;
  logic [1:0]  req_acc = 2'd0;
  logic [1:0]  req_cpl = 2'd0;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [23:0] rsp_addr;
  logic [2:0]  rsp_fault;

  always #5 clk = ~clk;

  seg_xlate_unit dut_i (
    .clk (clk), .rst_n (rst_n),
    .cfg_op (cfg_op), .cfg_cpl (cfg_cpl), .cfg_slot (cfg_slot),
    .cfg_base (cfg_base), .cfg_bound (cfg_bound), .cfg_perm (cfg_perm),
    .cfg_dpl (cfg_dpl), .cfg_limit (cfg_limit),
    .req_valid (req_valid), .req_ready (req_ready), .req_sel (req_sel),
    .req_off (req_off), .req_acc (req_acc), .req_cpl (req_cpl),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_addr (rsp_addr), .rsp_fault (rsp_fault)
  );

  int n_vec = 0;
  int n_bad = 0;

  // ---------------- behavioural reference model ----------------
  int m_base [32];
  int m_bound[32];
  int m_perm [32];
  int m_dpl  [32];
  int m_start[2];
  int m_limit[2];
  int m_phase = 0;   // 0 waiting, 1 checking, 2 result held
  int m_addr  = 0;
  int m_fault = 0;

  function automatic void m_lookup(int sel, int off, int acc, int cpl);
    int idx, tbl, rpl, slot, eff;
    idx  = sel / 8;
    tbl  = (sel / 4) % 2;
    rpl  = sel % 4;
    slot = (m_start[tbl] + idx) % 32;
    eff  = (cpl > rpl) ? cpl : rpl;
    if (idx > m_limit[tbl])                             m_fault = 1;
    else if (eff > m_dpl[slot])                         m_fault = 2;
    else if (acc == 3 || ((m_perm[slot] >> acc) % 2) == 0) m_fault = 3;
    else if (off > m_bound[slot])                       m_fault = 4;
    else                                                m_fault = 0;
    m_addr = (m_fault != 0) ? 0 : (m_base[slot] + off) % (1 << 24);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_base[i] = 0; m_bound[i] = 0; m_perm[i] = 0; m_dpl[i] = 0;
      end
      m_start[0] = 0; m_start[1] = 0; m_limit[0] = 0; m_limit[1] = 0;
      m_phase = 0; m_addr = 0; m_fault = 0;
    end else begin
      // lookup uses state from before any same-edge write (R11)
      case (m_phase)
        0: if (req_valid) begin
             m_lookup(int'(req_sel), int'(req_off), int'(req_acc), int'(req_cpl));
             m_phase = 1;
           end
        1: m_phase = 2;
        default: if (rsp_ready) m_phase = 0;
      endcase
      if (cfg_cpl == 2'd0) begin
        if (cfg_op == 2'd1) begin
          m_base[cfg_slot]  = int'(cfg_base);
          m_bound[cfg_slot] = int'(cfg_bound);
          m_perm[cfg_slot]  = int'(cfg_perm);
          m_dpl[cfg_slot]   = int'(cfg_dpl);
        end else if (cfg_op == 2'd2) begin
          m_start[0] = int'(cfg_slot); m_limit[0] = int'(cfg_limit);
        end else if (cfg_op == 2'd3) begin
          m_start[1] = int'(cfg_slot); m_limit[1] = int'(cfg_limit);
        end
      end
    end
  end

  function automatic string fault_req(int f);
    case (f)
      0: return "R7";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // ---------------- per-cycle comparison, away from the edge ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (req_ready !== (m_phase == 0) || rsp_valid !== (m_phase == 2)) begin
        n_bad++;
        $display("FAIL R9/R10 handshake: ready=%0b valid=%0b expected ready=%0b valid=%0b",
                 req_ready, rsp_valid, m_phase == 0, m_phase == 2);
      end else if (m_phase == 2 &&
                   (rsp_fault !== 3'(m_fault) || rsp_addr !== 24'(m_addr))) begin
        n_bad++;
        $display("FAIL %s result: addr=%06h fault=%0d expected addr=%06h fault=%0d",
                 fault_req(m_fault), rsp_addr, rsp_fault, m_addr, m_fault);
      end
    end
  end

  // ---------------- output backpressure ----------------
  int bp_mode = 0;  // 0 always ready, 1 random, 2 stalled
  always @(negedge clk) begin
    case (bp_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = ($urandom % 3) != 0;
      default: rsp_ready = 1'b0;
    endcase
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfg_wr(int op, int cpl, int slot, int base, int bound,
                        int perm, int dpl, int limit);
    @(negedge clk);
    cfg_op = 2'(op); cfg_cpl = 2'(cpl); cfg_slot = 5'(slot);
    cfg_base = 24'(base); cfg_bound = 16'(bound); cfg_perm = 3'(perm);
    cfg_dpl = 2'(dpl); cfg_limit = 13'(limit);
    @(negedge clk);
    cfg_op = 2'd0;
  endtask

  function automatic int mk_sel(int idx, int tbl, int rpl);
    return idx * 8 + tbl * 4 + rpl;
  endfunction

  task automatic look(int sel, int off, int acc, int cpl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_sel = 16'(sel); req_off = 16'(off);
    req_acc = 2'(acc); req_cpl = 2'(cpl);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // ---------------- directed and random sequence ----------------
  initial begin
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, zero descriptor -> read has no flag -> permission fault
    look(mk_sel(0, 0, 0), 0, 0, 0);

    // R11: tables and descriptors from ring 0
    cfg_wr(2, 0, 0, 0, 0, 0, 0, 7);               // global: start 0, limit 7
    cfg_wr(3, 0, 16, 0, 0, 0, 0, 3);              // local: start 16, limit 3
    cfg_wr(1, 0, 0, 24'h100000, 16'h0FFF, 3'b101, 3, 0);
    cfg_wr(1, 0, 1, 24'hFFFF00, 16'hFFFF, 3'b011, 0, 0);
    cfg_wr(1, 0, 2, 24'h002000, 16'h0010, 3'b010, 2, 0);
    cfg_wr(1, 0, 16, 24'h400000, 16'h07FF, 3'b011, 3, 0);
    cfg_wr(1, 0, 17, 24'h050000, 16'hFFFF, 3'b100, 3, 0);
    cfg_wr(1, 0, 20, 24'h600000, 16'hFFFF, 3'b011, 3, 0);

    // R2/R7: global index 0 from ring 3
    look(mk_sel(0, 0, 3), 16'h0123, 0, 3);
    // R6: offset equal to the bound, then one past it
    look(mk_sel(0, 0, 0), 16'h0FFF, 0, 3);
    look(mk_sel(0, 0, 0), 16'h1000, 0, 3);
    // R5: execute allowed, write refused, kind 3 refused
    look(mk_sel(0, 0, 0), 16'h0010, 2, 3);
    look(mk_sel(0, 0, 0), 16'h0010, 1, 3);
    look(mk_sel(0, 0, 0), 16'h0010, 3, 0);
    // R4: ring 3 on a ring-0 segment; ring 0 with requested ring 3
    look(mk_sel(1, 0, 0), 16'h0200, 0, 3);
    look(mk_sel(1, 0, 3), 16'h0200, 0, 0);
    // R7: base + offset wraps at 2^24
    look(mk_sel(1, 0, 0), 16'h0200, 1, 0);
    // R4: max(cpl, rpl) against minimum ring 2
    look(mk_sel(2, 0, 2), 16'h0004, 1, 1);
    look(mk_sel(2, 0, 1), 16'h0004, 1, 2);
    look(mk_sel(2, 0, 0), 16'h0004, 1, 3);
    // R8: privilege, permission and bound all fail -> privilege reported
    look(mk_sel(2, 0, 0), 16'h0020, 0, 3);
    // R8: permission and bound fail -> permission reported
    look(mk_sel(2, 0, 0), 16'h0020, 0, 0);
    // R8: limit beats everything; R3 index 7 at the limit reads zero slot
    look(mk_sel(8, 0, 3), 16'hFFFF, 3, 3);
    look(mk_sel(7, 0, 0), 16'h0000, 0, 0);
    // R2/R3: local table through start 16
    look(mk_sel(0, 1, 0), 16'h07FF, 1, 3);
    look(mk_sel(1, 1, 0), 16'h0042, 2, 3);
    look(mk_sel(4, 1, 0), 16'h0000, 0, 0);

    // R11: write from ring 1 is ignored, old descriptor still used
    cfg_wr(1, 1, 0, 24'hABCDEF, 16'hFFFF, 3'b111, 3, 0);
    look(mk_sel(0, 0, 0), 16'h0001, 0, 3);
    cfg_wr(3, 2, 0, 0, 0, 0, 0, 0);
    look(mk_sel(0, 1, 0), 16'h0001, 0, 3);

    // R12: context switch to local start 20, limit 0
    cfg_wr(3, 0, 20, 0, 0, 0, 0, 0);
    look(mk_sel(0, 1, 0), 16'h1234, 1, 3);
    look(mk_sel(1, 1, 0), 16'h0000, 0, 3);
    look(mk_sel(0, 0, 0), 16'h0123, 0, 3);

    // R11: descriptor write on the same edge as an accept
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_sel = 16'(mk_sel(0, 0, 0)); req_off = 16'h0005;
    req_acc = 2'd0; req_cpl = 2'd0;
    cfg_op = 2'd1; cfg_cpl = 2'd0; cfg_slot = 5'd0; cfg_base = 24'h777000;
    cfg_bound = 16'hFFFF; cfg_perm = 3'b001; cfg_dpl = 2'd0;
    @(negedge clk);
    req_valid = 1'b0; cfg_op = 2'd0;
    while (!req_ready) @(negedge clk);
    look(mk_sel(0, 0, 0), 16'h0005, 0, 0);

    // R10: hold the result under stall
    bp_mode = 2;
    @(negedge clk);
    req_valid = 1'b1; req_sel = 16'(mk_sel(0, 1, 0)); req_off = 16'h0099;
    req_acc = 2'd0; req_cpl = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    bp_mode = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);

    // random phase: lookups, config writes at random rings, random stalls
    bp_mode = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      req_valid = ($urandom % 2) == 1;
      req_sel   = 16'(mk_sel(int'($urandom % 10), int'($urandom % 2), int'($urandom % 4)));
      req_off   = ($urandom % 2) ? 16'($urandom % 64) : 16'($urandom);
      req_acc   = 2'($urandom % 4);
      req_cpl   = 2'($urandom % 4);
      cfg_op    = (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'd0;
      cfg_cpl   = (($urandom % 3) == 0) ? 2'($urandom % 4) : 2'd0;
      cfg_slot  = 5'($urandom % 32);
      cfg_base  = 24'($urandom);
      cfg_bound = 16'($urandom % 128);
      cfg_perm  = 3'($urandom % 8);
      cfg_dpl   = 2'($urandom % 4);
      cfg_limit = 13'($urandom % 10);
    end
    @(negedge clk);
    req_valid = 1'b0; cfg_op = 2'd0; bp_mode = 0;
    repeat (6) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule